// File: doc/BRIEF.md
# Host-Side Keyboard Controller Interface

This block is the host-facing half of a classic PC keyboard controller. The host sees two byte-wide locations: a data location and a combined command/status location. Behind them sit a mode byte, an output-port byte, a status byte and a one-entry latch that remembers which command armed the next data write. Two receive streams, one from the keyboard and one from the auxiliary pointing device, each land in a small FIFO. The block arbitrates between them, always serving keyboard bytes first, and raises a separate interrupt for each source.

Host accesses are decoded from an address: a location is the command/status location when its address has any bit in common with a mask parameter, and the data location otherwise. A mask of 0x04 gives the usual two locations four bytes apart. Bytes addressed to the devices leave on plain valid/data strobes. The block also drives the A20 gate line and a one-cycle system-reset request.

Top module: `kbc_host_if`

## Requirements
- R1: After reset the status byte reads 0x18, the mode byte reads back as 0x03, the output port reads back as 0x03, A20 is high and both interrupts and the reset request are low.
- R2: Status bit 0 is 1 whenever either FIFO holds data; status bit 5 is 1 only when the auxiliary FIFO holds data and the keyboard FIFO is empty; bit 4 is always 1, bits 1, 6 and 7 are always 0.
- R3: The keyboard interrupt is high exactly when the keyboard FIFO holds data, mode bit 0 is 1 and mode bit 4 is 0.
- R4: The auxiliary interrupt is high exactly when only the auxiliary FIFO holds data and mode bit 1 is 1.
- R5: A data-location read returns and removes the head of the auxiliary FIFO when it is the only one holding data, otherwise the head of the keyboard FIFO; with both empty it returns 0x00 and removes nothing. Read data appears one cycle after the read strobe.
- R6: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm the next data write to go to the mode byte, the output port, the keyboard FIFO, the auxiliary FIFO or the auxiliary transmit strobe respectively; that write disarms the latch.
- R7: A data write with nothing armed is sent out on the keyboard transmit strobe for one cycle.
- R8: Command 0x20 queues the mode byte to the keyboard FIFO, 0xD0 queues the output-port view, 0xAA sets status bit 2 and queues 0x55, and 0xA9, 0xAB and 0xC0 each queue 0x00.
- R9: Commands 0xA7/0xA8 set/clear mode bit 5 and 0xAD/0xAE set/clear mode bit 4, the latter taking effect on the keyboard interrupt at once.
- R10: Command 0xDF sets output-port bit 1 and A20, 0xDD clears both; a write through 0xD1 sets A20 from data bit 1; output-port bits 4 and 5 always read as status bits 0 and 5.
- R11: Any command with upper nibble 0xF and bit 0 clear, or an output-port write with bit 0 clear, pulses the reset request for one cycle; upper nibble 0xF with bit 0 set does nothing.
- R12: Status bit 3 is 1 after a command write and 0 after a data write.
- R13: Each FIFO holds 16 bytes and discards pushes while full; a command byte outside the listed set changes no state other than status bit 3.
- R14: Any address overlapping the mask reaches the command/status location and any other address reaches the data location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Host address, decoded against the mask |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Registered host read byte |
| kbd_rx_valid | input | 1 | Keyboard receive byte valid |
| kbd_rx_data | input | 8 | Keyboard receive byte |
| aux_rx_valid | input | 1 | Auxiliary receive byte valid |
| aux_rx_data | input | 8 | Auxiliary receive byte |
| kbd_tx_valid | output | 1 | Byte for the keyboard valid |
| kbd_tx_data | output | 8 | Byte for the keyboard |
| aux_tx_valid | output | 1 | Byte for the auxiliary device valid |
| aux_tx_data | output | 8 | Byte for the auxiliary device |
| irq_kbd | output | 1 | Keyboard interrupt level |
| irq_aux | output | 1 | Auxiliary interrupt level |
| a20_gate | output | 1 | A20 gate line |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume the host never raises read and write in the same cycle, that a device byte never arrives in the same cycle as an internally queued byte for the same FIFO (the internal byte wins), and that reset-requesting writes are not issued on consecutive cycles, since the one-cycle pulse check would otherwise see two pulses joined. The stimulus drives one host access per cycle, inserts an idle cycle after each reset-requesting write, and keeps device pushes apart from commands that queue responses. Under these conditions the interrupt outputs must always point at a FIFO that actually holds data, the read byte must not move without a read, and a data write must leave the command latch disarmed.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  // Command codes decoded on the command location
  localparam logic [7:0] OP_MODE_QUERY  = 8'h20;
  localparam logic [7:0] OP_MODE_LOAD   = 8'h60;
  localparam logic [7:0] OP_AUX_OFF     = 8'hA7;
  localparam logic [7:0] OP_AUX_ON      = 8'hA8;
  localparam logic [7:0] OP_AUX_PROBE   = 8'hA9;
  localparam logic [7:0] OP_SELF_CHECK  = 8'hAA;
  localparam logic [7:0] OP_KBD_PROBE   = 8'hAB;
  localparam logic [7:0] OP_KBD_OFF     = 8'hAD;
  localparam logic [7:0] OP_KBD_ON      = 8'hAE;
  localparam logic [7:0] OP_IN_QUERY    = 8'hC0;
  localparam logic [7:0] OP_PORT_QUERY  = 8'hD0;
  localparam logic [7:0] OP_PORT_LOAD   = 8'hD1;
  localparam logic [7:0] OP_KBUF_INJECT = 8'hD2;
  localparam logic [7:0] OP_ABUF_INJECT = 8'hD3;
  localparam logic [7:0] OP_AUX_SEND    = 8'hD4;
  localparam logic [7:0] OP_GATE_LOW    = 8'hDD;
  localparam logic [7:0] OP_GATE_HIGH   = 8'hDF;

  localparam logic [7:0] SELF_CHECK_OK  = 8'h55;

  // Mode byte bit positions
  localparam int MB_KIRQ = 0;
  localparam int MB_AIRQ = 1;
  localparam int MB_KOFF = 4;
  localparam int MB_AOFF = 5;

  // Output port bit positions
  localparam int OP_NRST = 0;
  localparam int OP_GATE = 1;

  typedef enum logic [2:0] {
    ARM_NONE, ARM_MODE, ARM_OUTP, ARM_KBUF, ARM_ABUF, ARM_AUXTX
  } arm_e;

  typedef enum logic [1:0] {
    RSP_MODE, RSP_PASS, RSP_ZERO, RSP_OUTP
  } rsp_e;

  typedef struct packed {
    arm_e arm;
    logic rsp_en;
    rsp_e rsp;
    logic selftest;
    logic aux_off;
    logic aux_on;
    logic kbd_off;
    logic kbd_on;
    logic gate_on;
    logic gate_off;
    logic rst_pulse;
  } ctl_act_t;

endpackage

// File: rtl/kbc_rx_fifo.sv
module kbc_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R13
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == CW'(DEPTH))); // R13
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (count == '0)); // R5

endmodule

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [7:0] cmd,
  output ctl_act_t   act
);
  always_comb begin
    act     = '0;
    act.arm = ARM_NONE;
    act.rsp = RSP_ZERO;
    if (cmd[7:4] == 4'hF) begin
      act.rst_pulse = ~cmd[0];
    end else begin
      case (cmd)
        OP_MODE_QUERY:  begin act.rsp_en = 1'b1; act.rsp = RSP_MODE; end
        OP_MODE_LOAD:   act.arm = ARM_MODE;
        OP_PORT_LOAD:   act.arm = ARM_OUTP;
        OP_KBUF_INJECT: act.arm = ARM_KBUF;
        OP_ABUF_INJECT: act.arm = ARM_ABUF;
        OP_AUX_SEND:    act.arm = ARM_AUXTX;
        OP_AUX_OFF:     act.aux_off = 1'b1;
        OP_AUX_ON:      act.aux_on  = 1'b1;
        OP_KBD_OFF:     act.kbd_off = 1'b1;
        OP_KBD_ON:      act.kbd_on  = 1'b1;
        OP_AUX_PROBE,
        OP_KBD_PROBE,
        OP_IN_QUERY:    begin act.rsp_en = 1'b1; act.rsp = RSP_ZERO; end
        OP_SELF_CHECK:  begin act.rsp_en = 1'b1; act.rsp = RSP_PASS; act.selftest = 1'b1; end
        OP_PORT_QUERY:  begin act.rsp_en = 1'b1; act.rsp = RSP_OUTP; end
        OP_GATE_HIGH:   act.gate_on  = 1'b1;
        OP_GATE_LOW:    act.gate_off = 1'b1;
        default:        act = act;
      endcase
    end
  end
endmodule

// File: rtl/kbc_src_arb.sv
module kbc_src_arb (
  input  logic kbd_has,
  input  logic aux_has,
  input  logic kirq_en,
  input  logic airq_en,
  input  logic kbd_off,
  output logic take_aux,
  output logic any_full,
  output logic aux_full,
  output logic irq_kbd_c,
  output logic irq_aux_c
);
  // Keyboard bytes always win when both streams hold data
  always_comb begin
    take_aux  = aux_has && !kbd_has;
    any_full  = kbd_has || aux_has;
    aux_full  = take_aux;
    irq_kbd_c = kbd_has && kirq_en && !kbd_off;
    irq_aux_c = take_aux && airq_en;
  end
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int         FIFO_DEPTH = 16,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] ADDR_MASK  = 8'h04,
  parameter logic [7:0] MODE_INIT  = 8'h03,
  parameter logic [7:0] OUTP_INIT  = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  input  logic              kbd_rx_valid,
  input  logic [7:0]        kbd_rx_data,
  input  logic              aux_rx_valid,
  input  logic [7:0]        aux_rx_data,
  output logic              kbd_tx_valid,
  output logic [7:0]        kbd_tx_data,
  output logic              aux_tx_valid,
  output logic [7:0]        aux_tx_data,
  output logic              irq_kbd,
  output logic              irq_aux,
  output logic              a20_gate,
  output logic              sys_reset_req
);
  localparam int CW = $clog2(FIFO_DEPTH+1);
  localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'(ADDR_MASK);
  localparam logic [7:0] OUTP_KEEP = 8'hCF;

  // Host access decode
  logic is_ctl, wr_cmd, wr_dat, rd_dat, rd_sts;
  assign is_ctl = |(host_addr & SEL_MASK);
  assign wr_cmd = host_wr &  is_ctl;
  assign wr_dat = host_wr & ~is_ctl;
  assign rd_dat = host_rd & ~is_ctl;
  assign rd_sts = host_rd &  is_ctl;

  // State
  logic [7:0] mode_q, outp_q;
  logic       selftest_q, cmdflag_q;
  arm_e       arm_q;

  ctl_act_t act;
  kbc_cmd_decode u_dec (.cmd(host_wdata), .act(act));

  // FIFOs and arbitration
  logic [7:0]    k_head, a_head, k_din, a_din, rsp_byte;
  logic [CW-1:0] k_cnt, a_cnt;
  logic          k_push, a_push, k_pop, a_pop, k_int, a_int;
  logic          kbd_has, aux_has, take_aux, any_full, aux_full;
  logic          irq_kbd_c, irq_aux_c;

  assign kbd_has = (k_cnt != '0);
  assign aux_has = (a_cnt != '0);

  kbc_src_arb u_arb (
    .kbd_has  (kbd_has),
    .aux_has  (aux_has),
    .kirq_en  (mode_q[MB_KIRQ]),
    .airq_en  (mode_q[MB_AIRQ]),
    .kbd_off  (mode_q[MB_KOFF]),
    .take_aux (take_aux),
    .any_full (any_full),
    .aux_full (aux_full),
    .irq_kbd_c(irq_kbd_c),
    .irq_aux_c(irq_aux_c)
  );

  logic [7:0] outp_view, status;
  assign outp_view = outp_q | {2'b00, aux_full, any_full, 4'b0000};
  assign status    = {2'b00, aux_full, 1'b1, cmdflag_q, selftest_q, 1'b0, any_full};

  always_comb begin
    case (act.rsp)
      RSP_MODE: rsp_byte = mode_q;
      RSP_PASS: rsp_byte = SELF_CHECK_OK;
      RSP_OUTP: rsp_byte = outp_view;
      default:  rsp_byte = 8'h00;
    endcase
  end

  // Internally generated bytes take the single write port ahead of devices
  assign k_int  = (wr_cmd && act.rsp_en) || (wr_dat && arm_q == ARM_KBUF);
  assign a_int  = wr_dat && arm_q == ARM_ABUF;
  assign k_din  = k_int ? (wr_cmd ? rsp_byte : host_wdata) : kbd_rx_data;
  assign a_din  = a_int ? host_wdata : aux_rx_data;
  assign k_push = k_int || kbd_rx_valid;
  assign a_push = a_int || aux_rx_valid;
  assign a_pop  = rd_dat && take_aux;
  assign k_pop  = rd_dat && kbd_has;

  kbc_rx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_kfifo (
    .clk(clk), .rst(rst), .push(k_push), .din(k_din),
    .pop(k_pop), .dout(k_head), .count(k_cnt)
  );

  kbc_rx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_afifo (
    .clk(clk), .rst(rst), .push(a_push), .din(a_din),
    .pop(a_pop), .dout(a_head), .count(a_cnt)
  );

  assign irq_kbd  = irq_kbd_c;
  assign irq_aux  = irq_aux_c;
  assign a20_gate = outp_q[OP_GATE];

  // Register updates
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= MODE_INIT;
      outp_q        <= OUTP_INIT & OUTP_KEEP;
      selftest_q    <= 1'b0;
      cmdflag_q     <= 1'b1;
      arm_q         <= ARM_NONE;
      kbd_tx_valid  <= 1'b0;
      kbd_tx_data   <= 8'h00;
      aux_tx_valid  <= 1'b0;
      aux_tx_data   <= 8'h00;
      sys_reset_req <= 1'b0;
      host_rdata    <= 8'h00;
    end else begin
      kbd_tx_valid  <= 1'b0;
      aux_tx_valid  <= 1'b0;
      sys_reset_req <= 1'b0;

      if (rd_sts) host_rdata <= status;
      else if (rd_dat) host_rdata <= take_aux ? a_head : (kbd_has ? k_head : 8'h00);

      if (wr_cmd) begin
        cmdflag_q <= 1'b1;
        if (act.arm != ARM_NONE) arm_q <= act.arm;
        if (act.selftest) selftest_q <= 1'b1;
        if (act.aux_off)  mode_q[MB_AOFF] <= 1'b1;
        if (act.aux_on)   mode_q[MB_AOFF] <= 1'b0;
        if (act.kbd_off)  mode_q[MB_KOFF] <= 1'b1;
        if (act.kbd_on)   mode_q[MB_KOFF] <= 1'b0;
        if (act.gate_on)  outp_q[OP_GATE] <= 1'b1;
        if (act.gate_off) outp_q[OP_GATE] <= 1'b0;
        sys_reset_req <= act.rst_pulse;
      end else if (wr_dat) begin
        cmdflag_q <= 1'b0;
        arm_q     <= ARM_NONE;
        case (arm_q)
          ARM_NONE: begin
            kbd_tx_valid <= 1'b1;
            kbd_tx_data  <= host_wdata;
          end
          ARM_MODE: mode_q <= host_wdata;
          ARM_OUTP: begin
            outp_q        <= host_wdata & OUTP_KEEP;
            sys_reset_req <= ~host_wdata[OP_NRST];
          end
          ARM_AUXTX: begin
            aux_tx_valid <= 1'b1;
            aux_tx_data  <= host_wdata;
          end
          default: arm_q <= ARM_NONE;
        endcase
      end
    end
  end

  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_dat |=> (arm_q == ARM_NONE)); // R6
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata)); // R5
  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (rst)
    sys_reset_req |=> !sys_reset_req); // R11
  AST_KIRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_kbd |-> (k_cnt != '0) && !mode_q[MB_KOFF]); // R3
  AST_AIRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_aux |-> (a_cnt != '0) && (k_cnt == '0)); // R4
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_kbd, irq_aux})); // R2
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (rst)
    kbd_tx_valid |-> $past(wr_dat)); // R7

endmodule

// File: tb/kbc_host_if_tb.sv
module kbc_host_if_tb;
  localparam logic [7:0] A_DATA = 8'h60;
  localparam logic [7:0] A_CTL  = 8'h64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       kbd_rx_valid = 1'b0, aux_rx_valid = 1'b0;
  logic [7:0] kbd_rx_data = 8'h00, aux_rx_data = 8'h00;
  logic       kbd_tx_valid, aux_tx_valid, irq_kbd, irq_aux, a20_gate, sys_reset_req;
  logic [7:0] kbd_tx_data, aux_tx_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #5 clk = ~clk;

  kbc_host_if u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .kbd_rx_valid(kbd_rx_valid), .kbd_rx_data(kbd_rx_data),
    .aux_rx_valid(aux_rx_valid), .aux_rx_data(aux_rx_data),
    .kbd_tx_valid(kbd_tx_valid), .kbd_tx_data(kbd_tx_data),
    .aux_tx_valid(aux_tx_valid), .aux_tx_data(aux_tx_data),
    .irq_kbd(irq_kbd), .irq_aux(irq_aux), .a20_gate(a20_gate),
    .sys_reset_req(sys_reset_req)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: compares each read result against the scoreboard queue
  always @(posedge clk) rd_seen <= host_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read actual=%02h expected=none", host_rdata);
      end else begin
        chk(host_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic kpush(input logic [7:0] d);
    kbd_rx_data = d; kbd_rx_valid = 1'b1;
    @(negedge clk);
    kbd_rx_valid = 1'b0;
  endtask

  task automatic apush(input logic [7:0] d);
    aux_rx_data = d; aux_rx_valid = 1'b1;
    @(negedge clk);
    aux_rx_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk({6'b0, irq_kbd, irq_aux}, 8'h00, "R1 irqs after reset");
    chk({7'b0, a20_gate}, 8'h01, "R1 a20 after reset");
    chk({7'b0, sys_reset_req}, 8'h00, "R1 reset req idle");
    rd(A_CTL, 8'h18, "R1 status after reset");
    wr(A_CTL, 8'h20);
    chk({7'b0, irq_kbd}, 8'h01, "R3 kbd irq with byte queued");
    rd(A_CTL, 8'h19, "R2 status obf");
    rd(A_DATA, 8'h03, "R1 R8 mode reset value");
    chk({7'b0, irq_kbd}, 8'h00, "R3 kbd irq drops when empty");
    wr(A_CTL, 8'hD0);
    rd(A_DATA, 8'h03, "R1 output port reset value");

    // R2 R3 R4 R5 arbitration
    apush(8'h9A);
    chk({6'b0, irq_kbd, irq_aux}, 8'h01, "R4 aux irq alone");
    rd(A_CTL, 8'h39, "R2 status aux only");
    kpush(8'h1C);
    chk({6'b0, irq_kbd, irq_aux}, 8'h02, "R3 kbd wins when both");
    rd(A_CTL, 8'h19, "R2 status both held");
    rd(A_DATA, 8'h1C, "R5 kbd popped first");
    chk({6'b0, irq_kbd, irq_aux}, 8'h01, "R4 aux irq after kbd drained");
    rd(A_DATA, 8'h9A, "R5 aux popped");
    rd(A_DATA, 8'h00, "R5 empty read");

    // R7 R12 unarmed data write
    wr(A_DATA, 8'h55);
    chk({7'b0, kbd_tx_valid}, 8'h01, "R7 kbd tx valid");
    chk(kbd_tx_data, 8'h55, "R7 kbd tx data");
    chk({7'b0, aux_tx_valid}, 8'h00, "R7 aux tx quiet");
    rd(A_CTL, 8'h10, "R12 status after data write");
    chk({7'b0, kbd_tx_valid}, 8'h00, "R7 kbd tx one cycle");

    // R6 armed writes
    wr(A_CTL, 8'hD4);
    wr(A_DATA, 8'hE8);
    chk({6'b0, aux_tx_valid, kbd_tx_valid}, 8'h02, "R6 aux tx routed");
    chk(aux_tx_data, 8'hE8, "R6 aux tx data");
    wr(A_DATA, 8'h11);
    chk({6'b0, aux_tx_valid, kbd_tx_valid}, 8'h01, "R6 latch cleared");
    chk(kbd_tx_data, 8'h11, "R6 kbd tx after clear");
    wr(A_CTL, 8'hD2);
    wr(A_DATA, 8'h77);
    chk({7'b0, irq_kbd}, 8'h01, "R6 kbd buffer injected");
    rd(A_DATA, 8'h77, "R6 kbd injected byte");
    wr(A_CTL, 8'hD3);
    wr(A_DATA, 8'h66);
    chk({7'b0, irq_aux}, 8'h01, "R6 aux buffer injected");
    rd(A_CTL, 8'h31, "R12 R2 status aux after data");
    rd(A_DATA, 8'h66, "R6 aux injected byte");

    // R3 R4 with interrupt enables cleared through mode write
    wr(A_CTL, 8'h60);
    wr(A_DATA, 8'h00);
    wr(A_CTL, 8'hD2);
    wr(A_DATA, 8'h44);
    chk({7'b0, irq_kbd}, 8'h00, "R3 kbd irq masked");
    rd(A_DATA, 8'h44, "R3 masked byte");
    wr(A_CTL, 8'hD3);
    wr(A_DATA, 8'h45);
    chk({7'b0, irq_aux}, 8'h00, "R4 aux irq masked");
    rd(A_DATA, 8'h45, "R4 masked byte");
    wr(A_CTL, 8'h60);
    wr(A_DATA, 8'h03);
    wr(A_CTL, 8'h20);
    rd(A_DATA, 8'h03, "R6 mode loaded");

    // R9 enable/disable
    wr(A_CTL, 8'hAD);
    kpush(8'h12);
    chk({7'b0, irq_kbd}, 8'h00, "R9 kbd disabled no irq");
    wr(A_CTL, 8'hAE);
    chk({7'b0, irq_kbd}, 8'h01, "R9 kbd enabled irq");
    rd(A_DATA, 8'h12, "R9 held byte");
    wr(A_CTL, 8'hA7);
    wr(A_CTL, 8'h20);
    rd(A_DATA, 8'h23, "R9 aux off bit");
    wr(A_CTL, 8'hA8);
    wr(A_CTL, 8'h20);
    rd(A_DATA, 8'h03, "R9 aux on bit");

    // R10 R11 gate and output port
    wr(A_CTL, 8'hDD);
    chk({7'b0, a20_gate}, 8'h00, "R10 gate low");
    wr(A_CTL, 8'hD0);
    rd(A_DATA, 8'h01, "R10 port bit1 cleared");
    wr(A_CTL, 8'hDF);
    chk({7'b0, a20_gate}, 8'h01, "R10 gate high");
    wr(A_CTL, 8'hD1);
    wr(A_DATA, 8'h01);
    chk({6'b0, a20_gate, sys_reset_req}, 8'h00, "R10 port write gate low");
    idle(1);
    wr(A_CTL, 8'hD1);
    wr(A_DATA, 8'hC2);
    chk({6'b0, a20_gate, sys_reset_req}, 8'h03, "R11 port write reset pulse");
    idle(1);
    chk({7'b0, sys_reset_req}, 8'h00, "R11 pulse one cycle");
    wr(A_CTL, 8'hD0);
    rd(A_DATA, 8'hC2, "R10 port upper bits kept");
    wr(A_CTL, 8'hD1);
    wr(A_DATA, 8'h33);
    wr(A_CTL, 8'hD0);
    rd(A_DATA, 8'h03, "R10 bits4 5 mirror flags");
    kpush(8'h5A);
    wr(A_CTL, 8'hD0);
    rd(A_DATA, 8'h5A, "R10 byte before view");
    rd(A_DATA, 8'h13, "R10 bit4 mirrors obf");

    // R11 upper nibble F
    idle(1);
    wr(A_CTL, 8'hF0);
    chk({7'b0, sys_reset_req}, 8'h01, "R11 F0 pulses");
    idle(1);
    chk({7'b0, sys_reset_req}, 8'h00, "R11 F0 pulse ends");
    wr(A_CTL, 8'hFF);
    chk({7'b0, sys_reset_req}, 8'h00, "R11 FF no pulse");
    idle(1);
    wr(A_CTL, 8'hFE);
    chk({7'b0, sys_reset_req}, 8'h01, "R11 FE pulses");
    idle(1);

    // R13 unrecognised command
    wr(A_CTL, 8'h12);
    rd(A_CTL, 8'h18, "R13 unknown cmd no push");
    wr(A_CTL, 8'h20);
    rd(A_DATA, 8'h03, "R13 unknown cmd mode kept");
    chk({7'b0, a20_gate}, 8'h01, "R13 unknown cmd gate kept");

    // R8 responses
    wr(A_CTL, 8'hAA);
    rd(A_CTL, 8'h1D, "R8 selftest flag");
    rd(A_DATA, 8'h55, "R8 selftest byte");
    wr(A_CTL, 8'hA9);
    wr(A_CTL, 8'hAB);
    wr(A_CTL, 8'hC0);
    rd(A_CTL, 8'h1D, "R8 probes queued");
    rd(A_DATA, 8'h00, "R8 probe a");
    rd(A_DATA, 8'h00, "R8 probe b");
    rd(A_DATA, 8'h00, "R8 probe c");
    rd(A_CTL, 8'h1C, "R8 three probes drained");

    // R13 FIFO depth
    for (int i = 0; i < 18; i++) kpush(8'h30 + 8'(i));
    for (int i = 0; i < 16; i++) rd(A_DATA, 8'h30 + 8'(i), "R13 fifo order");
    rd(A_DATA, 8'h00, "R13 overflow dropped");

    // R14 address aliases
    wr(8'h6C, 8'h20);
    rd(8'h61, 8'h03, "R14 alias data");
    rd(8'h6D, 8'h1C, "R14 alias status");

    idle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R5 reads missing actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule